// File: doc/BRIEF.md
# Smart-Update Byte Store Controller

This block owns a 256-byte array of cells whose bits can only go to 1 through an erase and to 0 through a write, plus a 32-bit one-time protection vector that guards bytes 0 to 31. A command front end hands it a single request: an update or a protect, with an address and a data byte. The controller works out which of the two cell phases the new value actually needs, charges the matching number of processing clock pulses, and then commits the change. While it works it holds an active-low busy line low, and on completion it raises a one-cycle done pulse, with a fail flag when the request was refused.

A protect request first compares the offered byte with the stored byte and clears the protection bit only on an exact match. A cleared protection bit is never set again. Until the front end reports a read access or an answer-to-reset through `access_seen`, every request is refused. Refused requests are released quickly, well inside eight clocks. The storage is modelled as register arrays. Both the main array and the protection vector can be read at any time through combinational ports.

Top module: `cbu_ctrl`

## Requirements
- R1: After synchronous reset `busy_n` is 1, `done` and `fail` are 0, every main byte reads 0xFF, and every bit of `prot_bits` is 1. A protection bit of 1 means unprotected.
- R2: Before any `access_seen` pulse following reset, every request is refused. It holds `busy_n` low for 2 cycles, ends with `fail`=1, and changes no storage.
- R3: An update whose new byte has a 1 where the stored byte has a 0 (erase needed), and is not 0xFF (write needed), holds `busy_n` low for exactly 255 cycles. The stored byte then equals the new byte.
- R4: An update that needs no 0-to-1 change but some 1-to-0 change (write only) holds `busy_n` low for 124 cycles. The stored byte becomes old AND new.
- R5: An update that needs an erase and whose new byte is 0xFF (erase only) holds `busy_n` low for 124 cycles. The stored byte becomes 0xFF.
- R6: An update whose new byte equals the stored byte holds `busy_n` low for 2 cycles, reports no failure and leaves the byte unchanged.
- R7: An update to an address below 32 whose protection bit is 0 fails. The byte is unchanged, and `busy_n` returns to 1 within 8 cycles (2 here).
- R8: A protect request (`req_kind`=1) to an unprotected address below 32 whose data equals the stored byte holds `busy_n` low for 124 cycles, then clears that protection bit to 0. No other protection bit changes.
- R9: A protect request whose data differs from the stored byte fails within 2 cycles and leaves the protection bit at 1.
- R10: A protect request to an already protected address, or to any address of 32 or above, fails within 2 cycles.
- R11: A request presented while `busy_n` is 0 is ignored and changes no storage.
- R12: `done` is high for exactly one cycle: the first cycle in which `busy_n` is back at 1 after processing. `fail` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, one pulse per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| access_seen | input | 1 | Pulse: a read access or answer-to-reset took place; unlocks data changes |
| req_valid | input | 1 | Request strobe, taken when `busy_n` is 1 |
| req_kind | input | 1 | 0 = update byte, 1 = protect byte |
| req_addr | input | 8 | Byte address of the request |
| req_data | input | 8 | New data (update) or comparison data (protect) |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 8 | Stored byte at `rd_addr` |
| prot_bits | output | 32 | Raw protection vector, 1 = unprotected |
| busy_n | output | 1 | Low while a request is being processed |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Request refused; valid with `done` |

## Verification
The assertions assume that `req_valid` is a single-cycle strobe and that `access_seen` is pulsed only while `busy_n` is high. They also assume that reset is held for at least one clock edge before any request. The bench drives each request for one cycle at a falling edge and unlocks only between requests. It counts low cycles of `busy_n` from the first falling edge after acceptance, so every timing expectation follows directly from the pulse counts in the requirements. Storage is observed only through the read port and the protection vector.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    localparam int CBU_AW      = 8;
    localparam int CBU_DW      = 8;
    localparam int CBU_PROT    = 32;
    localparam int CBU_T_BOTH  = 255;
    localparam int CBU_T_ONE   = 124;
    localparam int CBU_T_NONE  = 2;
    localparam int CBU_T_FAIL  = 2;

    typedef enum logic {
        KIND_UPDATE  = 1'b0,
        KIND_PROTECT = 1'b1
    } kind_e;

    typedef enum logic [1:0] {
        PH_NONE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_WRITE = 2'd2,
        PH_BOTH  = 2'd3
    } phase_e;

    typedef struct packed {
        logic   fail;
        logic   mem_we;
        logic   prot_we;
        phase_e phases;
    } plan_t;

    // Phases an update needs, given the stored and the new byte.
    function automatic phase_e pick_phases(input logic [CBU_DW-1:0] old_b,
                                           input logic [CBU_DW-1:0] new_b);
        logic er;
        logic wr;
        er = |(new_b & ~old_b);
        wr = er ? (new_b != {CBU_DW{1'b1}}) : |(old_b & ~new_b);
        return phase_e'({wr, er});
    endfunction

endpackage

// File: rtl/cbu_store.sv
module cbu_store
    import cbu_pkg::*;
#(
    parameter int AW    = CBU_AW,
    parameter int DW    = CBU_DW,
    parameter int NPROT = CBU_PROT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_we,
    input  logic             prot_we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    look_addr,
    output logic [DW-1:0]    look_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [NPROT-1:0] prot_q
);
    localparam int DEPTH = 1 << AW;
    localparam int PAW   = $clog2(NPROT);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (mem_we) begin
            cells[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '1;
        end else if (prot_we) begin
            prot_q[wr_addr[PAW-1:0]] <= 1'b0;
        end
    end

    assign look_data = cells[look_addr];
    assign rd_data   = cells[rd_addr];

    // R8: a cleared protection bit never returns to 1
    assert_prot_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((prot_q & ~$past(prot_q)) == '0));

    // R7: no cell write lands on a protected low byte
    assert_protected_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_we && ((wr_addr >> PAW) == '0)) |-> prot_q[wr_addr[PAW-1:0]]);

endmodule

// File: rtl/cbu_planner.sv
module cbu_planner
    import cbu_pkg::*;
#(
    parameter int AW    = CBU_AW,
    parameter int DW    = CBU_DW,
    parameter int NPROT = CBU_PROT
) (
    input  kind_e            kind,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    data,
    input  logic [DW-1:0]    stored,
    input  logic [NPROT-1:0] prot_q,
    input  logic             unlocked,
    output plan_t            plan
);
    localparam int PAW = $clog2(NPROT);

    logic   in_low;
    logic   open_bit;
    phase_e ph;

    assign in_low   = (addr >> PAW) == '0;
    assign open_bit = in_low ? prot_q[addr[PAW-1:0]] : 1'b1;
    assign ph       = pick_phases(stored, data);

    always_comb begin
        plan = '{fail: 1'b0, mem_we: 1'b0, prot_we: 1'b0, phases: PH_NONE};
        if (!unlocked) begin
            plan.fail = 1'b1;
        end else if (kind == KIND_UPDATE) begin
            if (!open_bit) begin
                plan.fail = 1'b1;
            end else begin
                plan.phases = ph;
                plan.mem_we = (ph != PH_NONE);
            end
        end else begin
            if (!in_low || !open_bit || (data != stored)) begin
                plan.fail = 1'b1;
            end else begin
                plan.prot_we = 1'b1;
                plan.phases  = PH_WRITE;
            end
        end
    end

endmodule

// File: rtl/cbu_timer.sv
module cbu_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic          finish
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start && (cnt == '0)) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy   = (cnt != '0);
    assign finish = (cnt == CW'(1));

endmodule

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
    import cbu_pkg::*;
#(
    parameter int AW     = CBU_AW,
    parameter int DW     = CBU_DW,
    parameter int NPROT  = CBU_PROT,
    parameter int T_BOTH = CBU_T_BOTH,
    parameter int T_ONE  = CBU_T_ONE,
    parameter int T_NONE = CBU_T_NONE,
    parameter int T_FAIL = CBU_T_FAIL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             access_seen,
    input  logic             req_valid,
    input  logic             req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [NPROT-1:0] prot_bits,
    output logic             busy_n,
    output logic             done,
    output logic             fail
);
    localparam int CW = $clog2(T_BOTH + 1);

    logic          unlocked_q;
    logic          busy;
    logic          finish;
    logic          start;
    logic [DW-1:0] stored;
    plan_t         plan_d;
    plan_t         plan_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [CW-1:0] len_d;
    logic [8:0]    low_run;

    assign start = req_valid && !busy;

    cbu_planner #(.AW(AW), .DW(DW), .NPROT(NPROT)) u_plan (
        .kind     (kind_e'(req_kind)),
        .addr     (req_addr),
        .data     (req_data),
        .stored   (stored),
        .prot_q   (prot_bits),
        .unlocked (unlocked_q),
        .plan     (plan_d)
    );

    always_comb begin
        if (plan_d.fail) begin
            len_d = CW'(T_FAIL);
        end else begin
            unique case (plan_d.phases)
                PH_BOTH:           len_d = CW'(T_BOTH);
                PH_ERASE, PH_WRITE: len_d = CW'(T_ONE);
                default:           len_d = CW'(T_NONE);
            endcase
        end
    end

    cbu_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .len    (len_d),
        .busy   (busy),
        .finish (finish)
    );

    cbu_store #(.AW(AW), .DW(DW), .NPROT(NPROT)) u_store (
        .clk       (clk),
        .rst       (rst),
        .mem_we    (finish && plan_q.mem_we),
        .prot_we   (finish && plan_q.prot_we),
        .wr_addr   (addr_q),
        .wr_data   (data_q),
        .look_addr (req_addr),
        .look_data (stored),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .prot_q    (prot_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked_q <= 1'b0;
        end else if (access_seen) begin
            unlocked_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q <= '{fail: 1'b0, mem_we: 1'b0, prot_we: 1'b0, phases: PH_NONE};
            addr_q <= '0;
            data_q <= '0;
        end else if (start) begin
            plan_q <= plan_d;
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else begin
            done <= finish;
            fail <= finish && plan_q.fail;
        end
    end

    assign busy_n = !busy;

    // Length of the current low stretch, kept only for the release check.
    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            low_run <= '0;
        end else if (low_run != '1) begin
            low_run <= low_run + 1'b1;
        end
    end

    // R7, R9, R10: a refused request is released within 8 clocks
    assert_fail_release_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && plan_q.fail) |-> (low_run < 9'd8));

    // R2: nothing is stored while still locked
    assert_locked_nochange_R2: assert property (@(posedge clk) disable iff (rst)
        !unlocked_q |-> !(finish && (plan_q.mem_we || plan_q.prot_we)));

    // R11: a request during processing does not replace the captured one
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> ($stable(addr_q) && $stable(data_q)));

    // R12: completion is a single-cycle pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: done coincides with the release of the busy line
    assert_done_release_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_n && $past(!busy_n)));

endmodule

// File: tb/cbu_ctrl_bench.sv
module cbu_ctrl_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        access_seen = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [31:0] prot_bits;
    logic        busy_n;
    logic        done;
    logic        fail;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cbu_ctrl u_cbu_ctrl (
        .clk         (clk),
        .rst         (rst),
        .access_seen (access_seen),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .prot_bits   (prot_bits),
        .busy_n      (busy_n),
        .done        (done),
        .fail        (fail)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Issue one request; optionally present a second one mid-processing.
    task automatic run_req(input logic kind, input logic [7:0] a, input logic [7:0] d,
                           input bit inject, output int lows, output bit dn, output bit fl);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        lows = 0;
        while (!busy_n && lows < 1000) begin
            lows++;
            if (inject && lows == 3) begin
                req_valid = 1'b1;
                req_kind  = 1'b0;
                req_addr  = a + 8'd1;
                req_data  = 8'h22;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        dn = done;
        fl = fail;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        @(negedge clk);
        chk("R1", "busy_n after reset", busy_n, 1);
        chk("R1", "done after reset", done, 0);
        chk("R1", "fail after reset", fail, 0);
        chk("R1", "prot_bits after reset", prot_bits, 32'hFFFF_FFFF);
        read_byte(8'd0, v);   chk("R1", "byte 0", v, 8'hFF);
        read_byte(8'd255, v); chk("R1", "byte 255", v, 8'hFF);
    endtask

    task automatic t_locked;
        int lows; bit dn; bit fl; logic [7:0] v;
        run_req(1'b0, 8'd40, 8'h00, 0, lows, dn, fl);
        chk("R2", "low cycles while locked", lows, 2);
        chk("R2", "fail while locked", fl, 1);
        read_byte(8'd40, v);
        chk("R2", "byte untouched while locked", v, 8'hFF);
        run_req(1'b1, 8'd3, 8'hFF, 0, lows, dn, fl);
        chk("R2", "protect refused while locked", fl, 1);
        chk("R2", "prot untouched while locked", prot_bits, 32'hFFFF_FFFF);
        @(negedge clk);
        access_seen = 1'b1;
        @(negedge clk);
        access_seen = 1'b0;
    endtask

    task automatic t_phases;
        int lows; bit dn; bit fl; logic [7:0] v;
        run_req(1'b0, 8'd40, 8'h5A, 0, lows, dn, fl);
        chk("R4", "write-only low cycles", lows, 124);
        chk("R4", "write-only fail", fl, 0);
        chk("R12", "done at release", dn, 1);
        @(negedge clk);
        chk("R12", "done one cycle only", done, 0);
        read_byte(8'd40, v); chk("R4", "write-only result", v, 8'h5A);

        run_req(1'b0, 8'd40, 8'hA5, 0, lows, dn, fl);
        chk("R3", "erase+write low cycles", lows, 255);
        chk("R3", "erase+write fail", fl, 0);
        read_byte(8'd40, v); chk("R3", "erase+write result", v, 8'hA5);

        run_req(1'b0, 8'd40, 8'hFF, 0, lows, dn, fl);
        chk("R5", "erase-only low cycles", lows, 124);
        read_byte(8'd40, v); chk("R5", "erase-only result", v, 8'hFF);

        run_req(1'b0, 8'd200, 8'h81, 0, lows, dn, fl);
        chk("R4", "write-only high address", lows, 124);
        read_byte(8'd200, v); chk("R4", "high address result", v, 8'h81);
    endtask

    task automatic t_no_change;
        int lows; bit dn; bit fl; logic [7:0] v;
        run_req(1'b0, 8'd200, 8'h81, 0, lows, dn, fl);
        chk("R6", "unchanged low cycles", lows, 2);
        chk("R6", "unchanged fail", fl, 0);
        chk("R6", "unchanged done", dn, 1);
        read_byte(8'd200, v); chk("R6", "unchanged byte", v, 8'h81);
    endtask

    task automatic t_protect_ok;
        int lows; bit dn; bit fl;
        run_req(1'b0, 8'd5, 8'h3C, 0, lows, dn, fl);
        chk("R4", "prepare byte 5", lows, 124);
        run_req(1'b1, 8'd5, 8'h3C, 0, lows, dn, fl);
        chk("R8", "protect low cycles", lows, 124);
        chk("R8", "protect fail", fl, 0);
        chk("R8", "prot vector after protect", prot_bits, 32'hFFFF_FFDF);
    endtask

    task automatic t_protected_update;
        int lows; bit dn; bit fl; logic [7:0] v;
        run_req(1'b0, 8'd5, 8'h00, 0, lows, dn, fl);
        chk("R7", "protected update fail", fl, 1);
        chk("R7", "protected update released", lows <= 8, 1);
        chk("R7", "protected update low cycles", lows, 2);
        read_byte(8'd5, v); chk("R7", "protected byte kept", v, 8'h3C);
    endtask

    task automatic t_protect_fail;
        int lows; bit dn; bit fl;
        run_req(1'b1, 8'd6, 8'h00, 0, lows, dn, fl);
        chk("R9", "mismatch fail", fl, 1);
        chk("R9", "mismatch low cycles", lows, 2);
        chk("R9", "mismatch keeps bit", prot_bits[6], 1);
        run_req(1'b1, 8'd5, 8'h3C, 0, lows, dn, fl);
        chk("R10", "reprotect fail", fl, 1);
        chk("R10", "reprotect low cycles", lows, 2);
        run_req(1'b1, 8'd40, 8'hFF, 0, lows, dn, fl);
        chk("R10", "protect out of range fail", fl, 1);
        chk("R10", "prot vector unchanged", prot_bits, 32'hFFFF_FFDF);
    endtask

    task automatic t_busy_ignore;
        int lows; bit dn; bit fl; logic [7:0] v;
        run_req(1'b0, 8'd50, 8'h11, 1, lows, dn, fl);
        chk("R11", "first request timing", lows, 124);
        @(negedge clk);
        chk("R11", "no second run starts", busy_n, 1);
        read_byte(8'd50, v); chk("R11", "first request stored", v, 8'h11);
        read_byte(8'd51, v); chk("R11", "busy request ignored", v, 8'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked();
        t_phases();
        t_no_change();
        t_protect_ok();
        t_protected_update();
        t_protect_fail();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule